// File: doc/BRIEF.md
# Core Clock Enable Sequencer

This block produces one clock-enable level per processor core in a multi-core cluster, driven from a mask that software writes. A 1 in a mask bit keeps a core running, or restarts it at once. A 0 starts an orderly stop. The block first raises a top-priority warning interrupt to that core. It then counts a fixed grace interval so the core can save its context and halt, and only then drops the enable. The block drives enable levels only. The clock buffer or gate that consumes them sits elsewhere.

Each core has its own sequencer and counter, so mask writes that arrive at different times stop cores at different times. Core 0 is the primary core and is never stopped. The mask port is a valid/ready channel whose ready is always high: a write is taken on every cycle where `wr_valid` is high, and the port never applies back-pressure. Synchronous reset returns every core to the running state.

Top module: `cce_ctrl`

## Requirements
- R1: In the first cycle after reset, every `core_clk_en` bit is 1 and every `core_warn_irq` bit is 0.
- R2: When a write carries a 1 in mask bit i for a core whose enable is 0, `core_clk_en[i]` is 1 from the clock edge that takes the write, and `core_warn_irq[i]` stays 0.
- R3: When a write carries a 0 in mask bit i (i ≥ 1) for a running core, `core_warn_irq[i]` becomes 1 from the edge that takes the write, and `core_clk_en[i]` stays 1.
- R4: `core_clk_en[i]` and `core_warn_irq[i]` both fall to 0 on the edge exactly `WARN_CYCLES` cycles after the warning rose. The default is 2000.
- R5: Bit 0 of the mask is ignored. `core_clk_en[0]` is always 1 and `core_warn_irq[0]` is always 0.
- R6: A write with a 1 in bit i while core i is warning cancels the stop. The warning drops on that edge and the enable stays 1. This holds even when the write lands on the edge where the countdown would have expired.
- R7: Each core counts its own grace interval, measured from its own warning, whatever writes other cores receive.
- R8: A further 0 for a core that is already warning does not restart its countdown. A 0 for a core that is already stopped has no effect.
- R9: `wr_ready` is always 1.
- R10: An all-zero mask starts the stop sequence on every core except core 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Mask write strobe |
| wr_ready | output | 1 | Always 1, no back-pressure |
| wr_mask | input | N_CORES | Requested run state, one bit per core |
| core_clk_en | output | N_CORES | Clock enable per core |
| core_warn_irq | output | N_CORES | Level-7 shutdown warning per core |

## Verification
The mask is driven with the following patterns:
- A single-core stop. This shows the warning latency and the exact expiry edge.
- A second stop issued partway through the first. This shows that the counters are independent and that a repeated 0 does not restart a countdown.
- An all-zero write followed by a partial cancel. This tells the stopping cores apart from the cancelled core and from the primary core.
- A cancel placed exactly on the expiry edge. This shows that a cancel wins over the countdown.
- A write that clears only bit 0. This shows that the primary core ignores off requests.

// File: rtl/cce_pkg.sv
package cce_pkg;
  typedef enum logic [1:0] {
    SLOT_RUN  = 2'd0,
    SLOT_WARN = 2'd1,
    SLOT_HALT = 2'd2
  } slot_state_e;
endpackage

// File: rtl/cce_req_decode.sv
module cce_req_decode #(
  parameter int N_CORES = 6
) (
  input  logic               wr_valid,
  input  logic [N_CORES-1:0] wr_mask,
  output logic [N_CORES-1:0] go_on,
  output logic [N_CORES-1:0] go_off
);
  always_comb begin
    go_on  = wr_valid ? wr_mask  : '0;
    go_off = wr_valid ? ~wr_mask : '0;
  end
endmodule

// File: rtl/cce_core_slot.sv
module cce_core_slot
  import cce_pkg::*;
#(
  parameter int WARN_CYCLES = 2000,
  parameter bit IS_PRIMARY  = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic go_on,
  input  logic go_off,
  output logic clk_en,
  output logic warn_irq
);
  localparam int CNT_W = (WARN_CYCLES > 1) ? $clog2(WARN_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WARN_CYCLES - 1);

  slot_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (IS_PRIMARY) begin
      state_d = SLOT_RUN;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        SLOT_RUN: begin
          if (go_off) begin
            state_d = SLOT_WARN;
            cnt_d   = '0;
          end
        end
        SLOT_WARN: begin
          if (go_on) begin
            state_d = SLOT_RUN;             // cancel beats expiry
          end else if (cnt_q == LAST) begin
            state_d = SLOT_HALT;
          end else begin
            cnt_d = cnt_q + 1'b1;           // a repeated 0 keeps counting
          end
        end
        SLOT_HALT: begin
          if (go_on) state_d = SLOT_RUN;
        end
        default: state_d = SLOT_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SLOT_RUN;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign clk_en   = (state_q != SLOT_HALT);
  assign warn_irq = (state_q == SLOT_WARN);
endmodule

// File: rtl/cce_ctrl.sv
module cce_ctrl #(
  parameter int N_CORES     = 6,
  parameter int WARN_CYCLES = 2000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [N_CORES-1:0] wr_mask,
  output logic [N_CORES-1:0] core_clk_en,
  output logic [N_CORES-1:0] core_warn_irq
);
  logic [N_CORES-1:0] go_on, go_off;

  assign wr_ready = 1'b1;

  cce_req_decode #(.N_CORES(N_CORES)) u_dec (
    .wr_valid (wr_valid),
    .wr_mask  (wr_mask),
    .go_on    (go_on),
    .go_off   (go_off)
  );

  for (genvar i = 0; i < N_CORES; i++) begin : g_slot
    cce_core_slot #(
      .WARN_CYCLES (WARN_CYCLES),
      .IS_PRIMARY  (i == 0)
    ) u_slot (
      .clk      (clk),
      .rst      (rst),
      .go_on    (go_on[i]),
      .go_off   (go_off[i]),
      .clk_en   (core_clk_en[i]),
      .warn_irq (core_warn_irq[i])
    );
  end
endmodule

// File: rtl/cce_ctrl_chk.sv
module cce_ctrl_chk #(
  parameter int N_CORES     = 6,
  parameter int WARN_CYCLES = 2000
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_valid,
  input logic               wr_ready,
  input logic [N_CORES-1:0] wr_mask,
  input logic [N_CORES-1:0] core_clk_en,
  input logic [N_CORES-1:0] core_warn_irq
);
  localparam int HW = $clog2(WARN_CYCLES + 2);

  a_r9_always_ready: assert property (@(posedge clk) disable iff (rst) wr_ready);

  a_r5_primary_runs: assert property (@(posedge clk) disable iff (rst)
    core_clk_en[0] && !core_warn_irq[0]);

  for (genvar i = 1; i < N_CORES; i++) begin : g_core
    logic [HW-1:0] hold_q;
    always_ff @(posedge clk) begin
      if (rst || !core_warn_irq[i]) hold_q <= '0;
      else                          hold_q <= hold_q + 1'b1;
    end

    a_r3_warn_while_enabled: assert property (@(posedge clk) disable iff (rst)
      core_warn_irq[i] |-> core_clk_en[i]);

    a_r3_warn_from_write: assert property (@(posedge clk) disable iff (rst)
      $rose(core_warn_irq[i]) |-> $past(wr_valid && !wr_mask[i]));

    a_r2_r6_on_request: assert property (@(posedge clk) disable iff (rst)
      (wr_valid && wr_mask[i]) |=> (core_clk_en[i] && !core_warn_irq[i]));

    a_r4_full_interval: assert property (@(posedge clk) disable iff (rst)
      $fell(core_clk_en[i]) |-> (hold_q == HW'(WARN_CYCLES)));
  end
endmodule

bind cce_ctrl cce_ctrl_chk #(.N_CORES(N_CORES), .WARN_CYCLES(WARN_CYCLES)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .wr_valid      (wr_valid),
  .wr_ready      (wr_ready),
  .wr_mask       (wr_mask),
  .core_clk_en   (core_clk_en),
  .core_warn_irq (core_warn_irq)
);

// File: tb/tb_cce_ctrl.sv
`timescale 1ns/1ps
module tb_cce_ctrl;
  localparam int N = 6;
  localparam int WC = 2000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [N-1:0] wr_mask = '1;
  logic [N-1:0] core_clk_en, core_warn_irq;

  always #4 clk = ~clk;

  cce_ctrl #(.N_CORES(N), .WARN_CYCLES(WC)) dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_mask(wr_mask), .core_clk_en(core_clk_en), .core_warn_irq(core_warn_irq)
  );

  typedef struct {
    int    cyc;
    int    core;
    logic  en;
    logic  irq;
    string tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(input int c, input int core, input logic en, input logic irq, input string tag);
    exp_t e;
    int k;
    e.cyc = c; e.core = core; e.en = en; e.irq = irq; e.tag = tag;
    k = 0;
    while (k < q.size() && q[k].cyc <= c) k++;
    q.insert(k, e);
  endtask

  task automatic write_mask(input logic [N-1:0] m, output int w);
    wr_valid = 1'b1;
    wr_mask  = m;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    w = cyc;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // monitor: pops items as their cycle comes up
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (!rst) begin
        checks++;
        if (wr_ready !== 1'b1) begin
          failures++;
          $display("FAIL R9 wr_ready actual=%b expected=1", wr_ready);
        end
      end
      while (q.size() > 0 && q[0].cyc <= cyc) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (e.cyc != cyc || core_clk_en[e.core] !== e.en || core_warn_irq[e.core] !== e.irq) begin
          failures++;
          $display("FAIL %s core%0d cyc=%0d actual en=%b irq=%b expected en=%b irq=%b (due %0d)",
                   e.tag, e.core, cyc, core_clk_en[e.core], core_warn_irq[e.core], e.en, e.irq, e.cyc);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired at cyc=%0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int w1, w2, w3, w4, w5, w6, w7, w8, w9;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    for (int c = 0; c < N; c++) push(cyc + 1, c, 1'b1, 1'b0, "R1");
    @(negedge clk);

    // single stop of core 1: R3, R4
    write_mask(6'b111101, w1);
    push(w1, 1, 1'b1, 1'b1, "R3");
    push(w1, 0, 1'b1, 1'b0, "R5");
    push(w1 + WC - 1, 1, 1'b1, 1'b1, "R4");
    push(w1 + WC, 1, 1'b0, 1'b0, "R4");

    // staggered stop of core 2, repeated 0 for core 1: R7, R8
    wait_until(w1 + 500);
    write_mask(6'b111001, w2);
    push(w2, 2, 1'b1, 1'b1, "R7");
    push(w2, 1, 1'b1, 1'b1, "R8");
    push(w2 + WC - 1, 2, 1'b1, 1'b1, "R7");
    push(w2 + WC, 2, 1'b0, 1'b0, "R7");

    // restart core 1, core 2 stays halted: R2, R8
    wait_until(w2 + WC + 3);
    write_mask(6'b111011, w3);
    push(w3, 1, 1'b1, 1'b0, "R2");
    push(w3, 2, 1'b0, 1'b0, "R8");

    // all-zero mask then partial cancel of core 3: R10, R6, R5
    @(negedge clk);
    write_mask(6'b000000, w4);
    push(w4, 0, 1'b1, 1'b0, "R5");
    push(w4, 2, 1'b0, 1'b0, "R8");
    for (int c = 1; c < N; c++) if (c != 2) push(w4, c, 1'b1, 1'b1, "R10");
    wait_until(w4 + 100);
    write_mask(6'b001000, w5);
    push(w5, 3, 1'b1, 1'b0, "R6");
    for (int c = 1; c < N; c++) if (c != 2 && c != 3) begin
      push(w4 + WC - 1, c, 1'b1, 1'b1, "R10");
      push(w4 + WC, c, 1'b0, 1'b0, "R10");
    end
    push(w4 + WC, 3, 1'b1, 1'b0, "R6");
    push(w4 + WC, 0, 1'b1, 1'b0, "R10");

    // all back on: R2
    wait_until(w4 + WC + 3);
    write_mask(6'b111111, w6);
    for (int c = 0; c < N; c++) push(w6, c, 1'b1, 1'b0, "R2");

    // off request to core 0 only is ignored: R5
    @(negedge clk);
    write_mask(6'b111110, w7);
    for (int c = 0; c < N; c++) push(w7, c, 1'b1, 1'b0, "R5");
    push(w7 + 10, 0, 1'b1, 1'b0, "R5");

    // cancel on the expiry edge: R6
    wait_until(w7 + 12);
    write_mask(6'b111011, w8);
    push(w8, 2, 1'b1, 1'b1, "R3");
    wait_until(w8 + WC - 1);
    write_mask(6'b111111, w9);
    push(w9, 2, 1'b1, 1'b0, "R6");
    push(w9 + 5, 2, 1'b1, 1'b0, "R6");

    wait_until(w9 + 8);
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule